// File: doc/BRIEF.md
# RTC Bus Transaction Monitor

This block sits beside an I2C event decoder and listens, without ever driving the bus, to the accesses made to a real-time-clock slave. Each cycle it may receive one already-decoded bus event: a start, a repeated start, an address byte in either direction, a data byte in either direction, or a stop. From that stream it follows the usual clock-chip access pattern. A write sets a register pointer and may carry a burst of data. A read first sets the pointer with a write, then issues a repeated start and reads a burst back.

Each data byte goes to the register the pointer currently selects, and the pointer then steps up by one. When a byte lands on one of the six time-and-date registers, the block drops that field's unused upper bits, converts the packed decimal value to binary and keeps it in a shadow register. At the stop that ends a data phase it raises a one-cycle completion strobe. That strobe comes with the direction of the transaction, the six binary fields, a mask of the fields written in this transaction, and the supply-low flag.

Top module: `rtc_bus_monitor`

## Requirements
- R1: After reset the monitor is idle, every time field reads 0xFF, the field mask is 0, the supply-low flag is 0 and the completion strobe is low.
- R2: Event codes are start=0, repeated start=1, address write=2, address read=3, data write=4, data read=5 and stop=6. While idle, every event except start is ignored and leaves all outputs unchanged.
- R3: After a start, only an address-write event with byte 0xA2 continues the transaction. After a repeated start, only an address-read event with byte 0xA3 continues it. Any other address event in those two waiting states returns the monitor to idle, so later data changes nothing and a stop gives no completion strobe.
- R4: The first data-write byte after the write address loads the register pointer. Each later data byte is applied to the register the pointer names, and the pointer then increments by one, also across registers that hold no time field.
- R5: Register 2 gives seconds from bits 6:0, register 3 minutes from bits 6:0, register 4 hours from bits 5:0, register 5 day of month from bits 5:0, register 7 month from bits 4:0, and register 8 year from bits 7:0. Each masked value is packed decimal and is converted as upper nibble times ten plus lower nibble.
- R6: Bit 7 of a byte applied to register 2 becomes the supply-low flag output.
- R7: A repeated start in the write data phase moves to a read sequence. After the read address, each data-read byte is applied with the same pointer auto-increment.
- R8: A stop in the write or read data phase gives the completion strobe for exactly one cycle, beginning the cycle after the stop event. The direction output is 1 for a read and 0 for a write.
- R9: A stop in any state returns the monitor to idle. A stop outside a data phase gives no completion strobe.
- R10: A start accepted in idle resets all six fields to 0xFF, the mask to 0 and the supply-low flag to 0. Mask bits 0 to 5 (seconds, minutes, hours, day, month, year) set when their field is written.
- R11: Events that do not fit the current state (such as a data read during a write data phase) are ignored: the pointer does not move and no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evValid | input | 1 | An event is present this cycle |
| evCode | input | 3 | Event code (see R2) |
| evData | input | 8 | Address or data byte of the event |
| doneValid | output | 1 | One-cycle completion strobe |
| doneRead | output | 1 | Direction of the completed transaction, 1 = read |
| timeSec | output | 8 | Seconds, binary |
| timeMin | output | 8 | Minutes, binary |
| timeHour | output | 8 | Hours, binary |
| timeDay | output | 8 | Day of month, binary |
| timeMonth | output | 8 | Month, binary |
| timeYear | output | 8 | Year within century, binary |
| fieldMask | output | 6 | Fields written in this transaction |
| voltLow | output | 1 | Supply-low flag from the seconds register |

## Verification
The assertions take for granted that the event decoder presents at most one event per cycle, always with one of the seven defined codes, and that events follow a legal bus order only loosely: any order is allowed, but the code value 7 never appears. The stimulus drives each event as a single-cycle valid pulse with a defined code and keeps the line idle between events. It then sweeps many time values through both full write bursts and pointer-then-read bursts. The high bits of those values carry deliberate junk, which exercises the field masking.

// File: rtl/rtcmon_pkg.sv
package rtcmon_pkg;

  localparam int NUM_FIELDS = 6;
  localparam logic [7:0] FIELD_INVALID = 8'hFF;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_ADDR_RD = 3'd3,
    EV_DATA_WR = 3'd4,
    EV_DATA_RD = 3'd5,
    EV_STOP    = 3'd6
  } evCode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_AW,
    S_WAIT_PTR,
    S_WR_DATA,
    S_WAIT_AR,
    S_RD_DATA
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic loadPtr;
    logic apply;
    logic report;
    logic isRead;
  } ctlStb_t;

  // register index holding field i (0 sec,1 min,2 hour,3 day,4 month,5 year)
  function automatic logic [7:0] fieldReg(input int i);
    case (i)
      0: return 8'h02;
      1: return 8'h03;
      2: return 8'h04;
      3: return 8'h05;
      4: return 8'h07;
      default: return 8'h08;
    endcase
  endfunction

  // significant bits of field i
  function automatic logic [7:0] fieldBits(input int i);
    case (i)
      0, 1: return 8'h7F;
      2, 3: return 8'h3F;
      4: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdToBin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

endpackage

// File: rtl/rtcmon_ctrl.sv
module rtcmon_ctrl
  import rtcmon_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hA2,
  parameter logic [7:0] RD_ADDR = 8'hA3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evValid,
  input  logic [2:0]    evCode,
  input  logic [7:0]    evData,
  output ctlStb_t       stb
);

  monState_t state, nextState;
  evCode_t   code;
  logic      isAddr;

  assign code   = evCode_t'(evCode);
  assign isAddr = (code == EV_ADDR_WR) || (code == EV_ADDR_RD);

  always_comb begin
    nextState = state;
    stb       = '0;
    if (evValid) begin
      if (code == EV_STOP) begin
        nextState  = S_IDLE;
        stb.report = (state == S_WR_DATA) || (state == S_RD_DATA);
        stb.isRead = (state == S_RD_DATA);
      end else begin
        case (state)
          S_IDLE: begin
            if (code == EV_START) begin
              nextState = S_WAIT_AW;
              stb.clear = 1'b1;
            end
          end
          S_WAIT_AW: begin
            if (code == EV_ADDR_WR && evData == WR_ADDR) nextState = S_WAIT_PTR;
            else if (isAddr)                             nextState = S_IDLE;
          end
          S_WAIT_PTR: begin
            if (code == EV_DATA_WR) begin
              nextState   = S_WR_DATA;
              stb.loadPtr = 1'b1;
            end
          end
          S_WR_DATA: begin
            if (code == EV_RSTART)       nextState = S_WAIT_AR;
            else if (code == EV_DATA_WR) stb.apply = 1'b1;
          end
          S_WAIT_AR: begin
            if (code == EV_ADDR_RD && evData == RD_ADDR) nextState = S_RD_DATA;
            else if (isAddr)                             nextState = S_IDLE;
          end
          S_RD_DATA: begin
            if (code == EV_DATA_RD) stb.apply = 1'b1;
          end
          default: nextState = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    evValid |-> evCode != 3'd7);  // R2

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (evValid && evCode == 3'd6) |=> state == S_IDLE);  // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !(evValid && evCode == 3'd0)) |=> state == S_IDLE);  // R2

  AST_READ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD_DATA && $past(state) != S_RD_DATA)
      |-> $past(evValid && evCode == 3'd3 && evData == RD_ADDR));  // R7

endmodule

// File: rtl/rtcmon_datapath.sv
module rtcmon_datapath
  import rtcmon_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  ctlStb_t                      stb,
  input  logic                         evValid,
  input  logic [2:0]                   evCode,
  input  logic [7:0]                   evData,
  output logic [NUM_FIELDS-1:0][7:0]   fieldVal,
  output logic [NUM_FIELDS-1:0]        maskR,
  output logic                         voltLow,
  output logic                         doneValid,
  output logic                         doneRead
);

  localparam logic [7:0] SEC_REG = fieldReg(0);

  logic [7:0] regPtr;

  always_ff @(posedge clk) begin
    if (rst)              regPtr <= '0;
    else if (stb.loadPtr) regPtr <= evData;
    else if (stb.apply)   regPtr <= regPtr + 8'd1;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [7:0] REG_IDX = fieldReg(i);
    localparam logic [7:0] BITS    = fieldBits(i);

    always_ff @(posedge clk) begin
      if (rst || stb.clear) begin
        fieldVal[i] <= FIELD_INVALID;
        maskR[i]    <= 1'b0;
      end else if (stb.apply && regPtr == REG_IDX) begin
        fieldVal[i] <= bcdToBin(evData & BITS);
        maskR[i]    <= 1'b1;
      end
    end

    AST_UNTOUCHED_INVALID: assert property (@(posedge clk) disable iff (rst)
      !maskR[i] |-> fieldVal[i] == FIELD_INVALID);  // R10
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clear)                      voltLow <= 1'b0;
    else if (stb.apply && regPtr == SEC_REG)   voltLow <= evData[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneValid <= 1'b0;
      doneRead  <= 1'b0;
    end else begin
      doneValid <= stb.report;
      if (stb.report) doneRead <= stb.isRead;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    stb.apply |=> regPtr == $past(regPtr) + 8'd1);  // R4

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    stb.loadPtr |=> regPtr == $past(evData));  // R4

  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (rst)
    stb.clear |=> maskR == '0);  // R10

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    doneValid |-> $past(evValid && evCode == 3'd6));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);  // R8

endmodule

// File: rtl/rtc_bus_monitor.sv
module rtc_bus_monitor
  import rtcmon_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hA2,
  parameter logic [7:0] RD_ADDR = 8'hA3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evValid,
  input  logic [2:0] evCode,
  input  logic [7:0] evData,
  output logic       doneValid,
  output logic       doneRead,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeDay,
  output logic [7:0] timeMonth,
  output logic [7:0] timeYear,
  output logic [5:0] fieldMask,
  output logic       voltLow
);

  ctlStb_t                       stb;
  logic [NUM_FIELDS-1:0][7:0]    fieldVal;

  rtcmon_ctrl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .evValid (evValid),
    .evCode  (evCode),
    .evData  (evData),
    .stb     (stb)
  );

  rtcmon_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .evValid   (evValid),
    .evCode    (evCode),
    .evData    (evData),
    .fieldVal  (fieldVal),
    .maskR     (fieldMask),
    .voltLow   (voltLow),
    .doneValid (doneValid),
    .doneRead  (doneRead)
  );

  assign timeSec   = fieldVal[0];
  assign timeMin   = fieldVal[1];
  assign timeHour  = fieldVal[2];
  assign timeDay   = fieldVal[3];
  assign timeMonth = fieldVal[4];
  assign timeYear  = fieldVal[5];

endmodule

// File: tb/sim_rtc_bus_monitor.sv
module sim_rtc_bus_monitor;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_START = 3'd0, C_RSTART = 3'd1, C_AW = 3'd2, C_AR = 3'd3,
                         C_DW = 3'd4, C_DR = 3'd5, C_STOP = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evValid = 1'b0;
  logic [2:0] evCode = '0;
  logic [7:0] evData = '0;
  logic doneValid, doneRead, voltLow;
  logic [7:0] timeSec, timeMin, timeHour, timeDay, timeMonth, timeYear;
  logic [5:0] fieldMask;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bus_monitor u0 (
    .clk(clk), .rst(rst), .evValid(evValid), .evCode(evCode), .evData(evData),
    .doneValid(doneValid), .doneRead(doneRead), .timeSec(timeSec), .timeMin(timeMin),
    .timeHour(timeHour), .timeDay(timeDay), .timeMonth(timeMonth), .timeYear(timeYear),
    .fieldMask(fieldMask), .voltLow(voltLow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one event as a single-cycle pulse; returns at the negedge after it was taken
  task automatic ev(input logic [2:0] c, input logic [7:0] d);
    @(negedge clk);
    evValid = 1'b1; evCode = c; evData = d;
    @(negedge clk);
    evValid = 1'b0;
  endtask

  function automatic logic [7:0] bcd(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  task automatic chkFields(input string req, input int s, input int mi, input int h,
                           input int d, input int mo, input int y);
    chk(req, timeSec, s);   chk(req, timeMin, mi); chk(req, timeHour, h);
    chk(req, timeDay, d);   chk(req, timeMonth, mo); chk(req, timeYear, y);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", doneValid, 0);
    chk("R1 mask", fieldMask, 0);
    chk("R1 vlow", voltLow, 0);
    chkFields("R1 fields", 255, 255, 255, 255, 255, 255);

    // R2 events in idle without start are ignored
    ev(C_AW, 8'hA2); ev(C_DW, 8'h02); ev(C_DW, 8'h45); ev(C_STOP, 8'h00);
    chk("R2 no done", doneValid, 0);
    chk("R2 mask", fieldMask, 0);
    chk("R2 sec", timeSec, 255);

    // R4 R5 R6 R8 R10 write burst sweep from register 2
    for (int v = 0; v < 60; v++) begin
      int s = v, mi = (v * 7) % 60, h = v % 24, d = 1 + v % 31, mo = 1 + v % 12, y = (v * 13) % 100;
      logic vl = v[0];
      ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_DW, 8'h02);
      ev(C_DW, {vl, bcd(s)[6:0]});
      ev(C_DW, bcd(mi) | {v[1], 7'd0});          // junk bit 7, R5 mask
      ev(C_DW, bcd(h) | {v[2:1], 6'd0});         // junk bits 7:6
      ev(C_DW, bcd(d) | {v[3:2], 6'd0});
      ev(C_DW, 8'h55);                            // register 6, no field (R4)
      ev(C_DW, bcd(mo) | {v[2:0], 5'd0});         // junk bits 7:5
      ev(C_DW, bcd(y));
      ev(C_STOP, 0);
      chk("R8 done write", doneValid, 1);
      chk("R8 dir write", doneRead, 0);
      chkFields("R5 write burst", s, mi, h, d, mo, y);
      chk("R10 mask full", fieldMask, 6'h3F);
      chk("R6 vlow", voltLow, vl);
      @(negedge clk);
      chk("R8 done one cycle", doneValid, 0);
    end

    // R7 pointer-then-read sweep
    for (int v = 0; v < 40; v++) begin
      int h = (v * 5) % 24, d = 1 + (v * 3) % 31;
      ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_DW, 8'h04);
      ev(C_RSTART, 0); ev(C_AR, 8'hA3);
      ev(C_DR, bcd(h)); ev(C_DR, bcd(d) | 8'hC0);
      ev(C_STOP, 0);
      chk("R7 done read", doneValid, 1);
      chk("R8 dir read", doneRead, 1);
      chk("R7 hour", timeHour, h);
      chk("R7 day", timeDay, d);
      chk("R10 mask partial", fieldMask, 6'b001100);
      chk("R10 sec invalid", timeSec, 255);
      chk("R10 vlow cleared", voltLow, 0);
    end

    // R3 foreign write address
    ev(C_START, 0); ev(C_AW, 8'hD0); ev(C_DW, 8'h02); ev(C_DW, 8'h15); ev(C_STOP, 0);
    chk("R3 foreign wr done", doneValid, 0);
    chk("R3 foreign wr mask", fieldMask, 0);
    chk("R3 foreign wr sec", timeSec, 255);

    // R3 foreign read address after repeated start
    ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_DW, 8'h03);
    ev(C_RSTART, 0); ev(C_AR, 8'hD1); ev(C_DR, 8'h22); ev(C_STOP, 0);
    chk("R3 foreign rd done", doneValid, 0);
    chk("R3 foreign rd min", timeMin, 255);

    // R11 unexpected data read in write phase is ignored
    ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_DW, 8'h02);
    ev(C_DR, 8'h45); ev(C_DW, 8'h30); ev(C_STOP, 0);
    chk("R11 sec", timeSec, 30);
    chk("R11 mask", fieldMask, 6'b000001);
    chk("R11 done", doneValid, 1);

    // R9 stop while waiting for pointer: idle, no strobe; next data ignored
    ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_STOP, 0);
    chk("R9 no done", doneValid, 0);
    ev(C_DW, 8'h02); ev(C_DW, 8'h11); ev(C_STOP, 0);
    chk("R9 idle after stop", fieldMask, 0);
    chk("R9 no done idle", doneValid, 0);

    // R4 pointer wrap into year then beyond: year at 8, byte to 9 ignored
    ev(C_START, 0); ev(C_AW, 8'hA2); ev(C_DW, 8'h07);
    ev(C_DW, bcd(9)); ev(C_DW, bcd(42)); ev(C_DW, 8'h33); ev(C_STOP, 0);
    chk("R4 month", timeMonth, 9);
    chk("R4 year", timeYear, 42);
    chk("R4 mask", fieldMask, 6'b110000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule